// File: doc/BRIEF.md
# Paletted Framebuffer Pixel Formatter

This block sits in the pixel path of a display controller, between memory fetch and the panel. It takes 32-bit framebuffer words and turns them into a stream of 24-bit RGB pixels. A 2-bit format code selects how each word is read. The word can hold palette indices of 8 or 4 bits, or it can hold direct 16-bit colour in one of two layouts: 5-5-5 with an unused top bit, or 5-6-5.

Software fills a 256-entry colour table through two registers. One register sets the table position. The other takes a 32-bit entry, stores it at that position and then moves the position on by one. Both streams use a valid/ready handshake. The format code is captured together with each word, so software may change it between words. Timing generation is not part of this block; the target panel is 854 by 480 pixels.

Top module: `fb_pixel_formatter`

## Requirements
- R1: After reset, pix_valid_o is 0, word_ready_o is 1, the write position is 0 and every table entry reads as zero colour.
- R2: A register write at offset 0x0 loads the write position from reg_wdata_i[7:0].
- R3: A register write at offset 0x4 stores reg_wdata_i at the current position, and the position then advances by one. The position wraps from 255 to 0.
- R4: Register writes at offsets other than 0x0 and 0x4 change neither the table nor the position.
- R5: With format code 0, a word yields four pixels from the byte fields, taken from bits 7:0 upward. Each byte indexes the table.
- R6: With format code 1, a word yields eight pixels from the 4-bit fields, taken from bits 3:0 upward. Each field indexes table entries 0 to 15.
- R7: With format code 2, a word yields two pixels from its 16-bit halves, low half first. Red is bits 14:10, green is bits 9:5 and blue is bits 4:0; bit 15 is ignored. Each 5-bit field v becomes the 8-bit value {v, v[4:2]}.
- R8: With format code 3, a word yields two 16-bit pixels, low half first. Red is bits 15:11, green is bits 10:5 and blue is bits 4:0. A 6-bit field g becomes {g, g[5:4]}, and the 5-bit fields expand as in R7.
- R9: A table entry supplies red from bits 7:0, green from bits 15:8 and blue from bits 23:16. Bits 31:24 are ignored. pix_rgb_o carries red in bits 23:16, green in 15:8 and blue in 7:0.
- R10: While a pixel is stalled (valid and not ready), pix_rgb_o and pix_valid_o hold. A new word is taken only when no pixel is pending, or in the cycle the last pixel of the current word is accepted.
- R11: The format code is sampled when a word is accepted. Changing fmt_i while that word is being sent has no effect on its pixels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fmt_i | input | 2 | Pixel format code, sampled with each word |
| word_valid_i | input | 1 | Framebuffer word valid |
| word_data_i | input | 32 | Framebuffer word |
| word_ready_o | output | 1 | Word accepted this cycle when valid is high |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| pix_valid_o | output | 1 | Output pixel valid |
| pix_rgb_o | output | 24 | Pixel colour, R in 23:16, G in 15:8, B in 7:0 |
| pix_ready_i | input | 1 | Downstream takes the pixel |

## Verification
The hardest case to reach from the ports is a new word arriving in the exact cycle the last pixel of the previous word leaves. It must be taken only then, and never one slot early. The bench streams words back to back with no gaps and drives a random ready pattern on the pixel side. This makes stalls land on every slot position in all four formats, including the last-slot handover. The position wrap is reached by setting the position to 255 and writing two entries. A format change is made while a word is still draining, to show that the code is sampled only when a word is accepted.

// File: rtl/fbpf_pkg.sv
package fbpf_pkg;
  typedef enum logic [1:0] {
    FMT_IDX8   = 2'd0,
    FMT_IDX4   = 2'd1,
    FMT_RGB555 = 2'd2,
    FMT_RGB565 = 2'd3
  } fmt_e;

  localparam int RGB_W  = 24;
  localparam int CODE_W = 16;

  function automatic logic [7:0] widen5(logic [4:0] v);
    return {v, v[4:2]};
  endfunction

  function automatic logic [7:0] widen6(logic [5:0] v);
    return {v, v[5:4]};
  endfunction
endpackage

// File: rtl/fbpf_palette.sv
module fbpf_palette
  import fbpf_pkg::*;
#(
  parameter int ENTRIES  = 256,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 3,
  parameter int POS_OFS  = 0,
  parameter int DATA_OFS = 4,
  localparam int IDX_W   = $clog2(ENTRIES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [RGB_W-1:0]  rd_rgb_o
);
  logic [IDX_W-1:0] pos_q;
  logic [RGB_W-1:0] mem_q [ENTRIES];
  logic [RGB_W-1:0] entry_rgb;
  logic             hit_pos, hit_data;

  assign hit_pos  = we_i && (addr_i == ADDR_W'(POS_OFS));
  assign hit_data = we_i && (addr_i == ADDR_W'(DATA_OFS));

  // channel c of the entry (c=0 red) lands in output byte 2-c
  for (genvar c = 0; c < 3; c++) begin : g_chan
    assign entry_rgb[RGB_W-1-8*c -: 8] = wdata_i[8*c +: 8];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q <= '0;
      for (int k = 0; k < ENTRIES; k++) mem_q[k] <= '0;
    end else if (hit_pos) begin
      pos_q <= wdata_i[IDX_W-1:0];
    end else if (hit_data) begin
      mem_q[pos_q] <= entry_rgb;
      pos_q        <= pos_q + 1'b1;
    end
  end

  assign rd_rgb_o = mem_q[rd_idx_i];

  p_pos_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_pos |=> pos_q == $past(wdata_i[IDX_W-1:0]));
  p_pos_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_data |=> pos_q == IDX_W'($past(pos_q) + 1'b1));
  p_other_ofs_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !hit_pos && !hit_data) |=> $stable(pos_q));
endmodule

// File: rtl/fbpf_unpack.sv
module fbpf_unpack
  import fbpf_pkg::*;
#(
  parameter int WORD_W  = 32,
  localparam int SLOT_W = $clog2(WORD_W / 4),
  localparam int SH_W   = $clog2(WORD_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        fmt_i,
  input  logic              word_valid_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              word_ready_o,
  output logic              pix_valid_o,
  input  logic              pix_ready_i,
  output fmt_e              fmt_o,
  output logic [CODE_W-1:0] code_o
);
  localparam logic [SLOT_W:0] N8  = (SLOT_W+1)'(WORD_W / 8);
  localparam logic [SLOT_W:0] N4  = (SLOT_W+1)'(WORD_W / 4);
  localparam logic [SLOT_W:0] N16 = (SLOT_W+1)'(WORD_W / 16);

  logic [WORD_W-1:0] word_q, shifted;
  fmt_e              fmt_q;
  logic [SLOT_W-1:0] slot_q;
  logic              full_q;
  logic [SLOT_W:0]   slot_cnt;
  logic [SH_W-1:0]   shamt;
  logic              last, take, fire;

  always_comb begin
    unique case (fmt_q)
      FMT_IDX8: begin slot_cnt = N8;  shamt = SH_W'(slot_q) << 3; end
      FMT_IDX4: begin slot_cnt = N4;  shamt = SH_W'(slot_q) << 2; end
      default:  begin slot_cnt = N16; shamt = SH_W'(slot_q) << 4; end
    endcase
  end

  assign last         = (slot_q == SLOT_W'(slot_cnt - 1'b1));
  assign fire         = full_q && pix_ready_i;
  assign word_ready_o = !full_q || (pix_ready_i && last);
  assign take         = word_valid_i && word_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      fmt_q  <= FMT_IDX8;
      slot_q <= '0;
      full_q <= 1'b0;
    end else if (take) begin
      word_q <= word_i;
      fmt_q  <= fmt_e'(fmt_i);
      slot_q <= '0;
      full_q <= 1'b1;
    end else if (fire) begin
      if (last) full_q <= 1'b0;
      else      slot_q <= slot_q + 1'b1;
    end
  end

  assign shifted     = word_q >> shamt;
  assign code_o      = shifted[CODE_W-1:0];
  assign fmt_o       = fmt_q;
  assign pix_valid_o = full_q;

  p_stall_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_q && !pix_ready_i) |=> full_q && $stable(slot_q) && $stable(word_q));
  p_fmt_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_q && !take) |=> $stable(fmt_q));
  p_slot_range_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_q |-> ({1'b0, slot_q} < slot_cnt));
endmodule

// File: rtl/fbpf_color.sv
module fbpf_color
  import fbpf_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  fmt_e              fmt_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [RGB_W-1:0]  pal_rgb_i,
  output logic [IDX_W-1:0]  pal_idx_o,
  output logic [RGB_W-1:0]  rgb_o
);
  always_comb begin
    pal_idx_o = code_i[IDX_W-1:0];
    if (fmt_i == FMT_IDX4) pal_idx_o = {{(IDX_W-4){1'b0}}, code_i[3:0]};
  end

  always_comb begin
    unique case (fmt_i)
      FMT_RGB555: rgb_o = {widen5(code_i[14:10]), widen5(code_i[9:5]),
                           widen5(code_i[4:0])};
      FMT_RGB565: rgb_o = {widen5(code_i[15:11]), widen6(code_i[10:5]),
                           widen5(code_i[4:0])};
      default:    rgb_o = pal_rgb_i;
    endcase
  end
endmodule

// File: rtl/fb_pixel_formatter.sv
module fb_pixel_formatter
  import fbpf_pkg::*;
#(
  parameter int WORD_W      = 32,
  parameter int PAL_ENTRIES = 256,
  parameter int REG_ADDR_W  = 3,
  localparam int IDX_W      = $clog2(PAL_ENTRIES)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [1:0]            fmt_i,
  input  logic                  word_valid_i,
  input  logic [WORD_W-1:0]     word_data_i,
  output logic                  word_ready_o,
  input  logic                  reg_we_i,
  input  logic [REG_ADDR_W-1:0] reg_addr_i,
  input  logic [31:0]           reg_wdata_i,
  output logic                  pix_valid_o,
  output logic [RGB_W-1:0]      pix_rgb_o,
  input  logic                  pix_ready_i
);
  fmt_e              cur_fmt;
  logic [CODE_W-1:0] cur_code;
  logic [IDX_W-1:0]  pal_idx;
  logic [RGB_W-1:0]  pal_rgb;

  fbpf_palette #(
    .ENTRIES (PAL_ENTRIES),
    .DATA_W  (32),
    .ADDR_W  (REG_ADDR_W)
  ) i_palette (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (reg_we_i),
    .addr_i   (reg_addr_i),
    .wdata_i  (reg_wdata_i),
    .rd_idx_i (pal_idx),
    .rd_rgb_o (pal_rgb)
  );

  fbpf_unpack #(
    .WORD_W (WORD_W)
  ) i_unpack (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .fmt_i        (fmt_i),
    .word_valid_i (word_valid_i),
    .word_i       (word_data_i),
    .word_ready_o (word_ready_o),
    .pix_valid_o  (pix_valid_o),
    .pix_ready_i  (pix_ready_i),
    .fmt_o        (cur_fmt),
    .code_o       (cur_code)
  );

  fbpf_color #(
    .IDX_W (IDX_W)
  ) i_color (
    .fmt_i     (cur_fmt),
    .code_i    (cur_code),
    .pal_rgb_i (pal_rgb),
    .pal_idx_o (pal_idx),
    .rgb_o     (pix_rgb_o)
  );

  p_out_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_valid_o && !pix_ready_i && !reg_we_i) |=> pix_valid_o && $stable(pix_rgb_o));
endmodule

// File: tb/test_fb_pixel_formatter.sv
module test_fb_pixel_formatter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  fmt_i = 2'd0;
  logic        word_valid_i = 1'b0;
  logic [31:0] word_data_i = '0;
  logic        word_ready_o;
  logic        reg_we_i = 1'b0;
  logic [2:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic        pix_valid_o;
  logic [23:0] pix_rgb_o;
  logic        pix_ready_i = 1'b1;

  always #4 clk = ~clk;

  fb_pixel_formatter i_fb_pixel_formatter (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .fmt_i        (fmt_i),
    .word_valid_i (word_valid_i),
    .word_data_i  (word_data_i),
    .word_ready_o (word_ready_o),
    .reg_we_i     (reg_we_i),
    .reg_addr_i   (reg_addr_i),
    .reg_wdata_i  (reg_wdata_i),
    .pix_valid_o  (pix_valid_o),
    .pix_rgb_o    (pix_rgb_o),
    .pix_ready_i  (pix_ready_i)
  );

  int          n_checks = 0;
  int          n_errors = 0;
  bit          done = 0;
  bit          rnd_ready = 0;
  logic [31:0] pal_m [256];
  int          pos_m = 0;
  logic [23:0] exp_q [$];
  string       tag_q [$];
  string       cur_tag = "R1";
  int          rem = 0;
  bit          prev_stall = 0;
  logic [23:0] prev_rgb = '0;

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int slots(int f);
    return (f == 0) ? 4 : (f == 1) ? 8 : 2;
  endfunction

  function automatic logic [7:0] x5(int v);
    return 8'(((v & 31) << 3) | ((v & 31) >> 2));
  endfunction

  function automatic logic [23:0] ref_pix(logic [31:0] w, int f, int i);
    int idx, h;
    logic [31:0] e;
    case (f)
      0: begin idx = int'((w >> (8*i)) & 32'hFF); e = pal_m[idx];
         return {e[7:0], e[15:8], e[23:16]}; end
      1: begin idx = int'((w >> (4*i)) & 32'hF); e = pal_m[idx];
         return {e[7:0], e[15:8], e[23:16]}; end
      2: begin h = int'((w >> (16*i)) & 32'hFFFF);
         return {x5(h >> 10), x5(h >> 5), x5(h)}; end
      default: begin h = int'((w >> (16*i)) & 32'hFFFF);
         return {x5(h >> 11), 8'((((h >> 5) & 63) << 2) | (((h >> 5) & 63) >> 4)), x5(h)}; end
    endcase
  endfunction

  // reference model and comparison, sampled mid-cycle
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(word_ready_o == ((rem == 0) || (rem == 1 && pix_ready_i)), "R10",
          32'(word_ready_o), 32'((rem == 0) || (rem == 1 && pix_ready_i)));
      chk(pix_valid_o == (rem != 0), "R10", 32'(pix_valid_o), 32'(rem != 0));
      if (prev_stall)
        chk(pix_valid_o && pix_rgb_o == prev_rgb, "R10", 32'(pix_rgb_o), 32'(prev_rgb));
      if (pix_valid_o && pix_ready_i) begin
        if (exp_q.size() == 0) chk(0, "R10", 32'(pix_rgb_o), 32'hFFFF_FFFF);
        else begin
          automatic logic [23:0] e = exp_q.pop_front();
          automatic string t = tag_q.pop_front();
          chk(pix_rgb_o == e, t, 32'(pix_rgb_o), 32'(e));
        end
        if (rem > 0) rem--;
      end
      if (word_valid_i && word_ready_o) begin
        for (int i = 0; i < slots(int'(fmt_i)); i++) begin
          exp_q.push_back(ref_pix(word_data_i, int'(fmt_i), i));
          tag_q.push_back(cur_tag);
        end
        rem += slots(int'(fmt_i));
      end
      prev_stall = pix_valid_o && !pix_ready_i;
      prev_rgb   = pix_rgb_o;
    end
  end

  always @(posedge clk) begin
    #1 pix_ready_i <= rnd_ready ? ($urandom_range(0, 3) != 0) : 1'b1;
  end

  task automatic reg_write(logic [2:0] a, logic [31:0] d);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(posedge clk); #1;
    reg_we_i = 1'b0;
    if (a == 3'd0) pos_m = int'(d[7:0]);
    else if (a == 3'd4) begin pal_m[pos_m] = d; pos_m = (pos_m + 1) % 256; end
  endtask

  task automatic send_word(logic [31:0] w, logic [1:0] f, string t);
    cur_tag = t; word_valid_i = 1'b1; word_data_i = w; fmt_i = f;
    forever begin
      @(negedge clk);
      if (word_ready_o) break;
    end
    @(posedge clk); #1;
    word_valid_i = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (rem != 0 || exp_q.size() != 0);
    @(posedge clk); #1;
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_errors++; n_checks++;
        $display("FAIL watchdog: actual=%0d expected<=100000", cyc);
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
      end
    end
  end

  initial begin
    for (int k = 0; k < 256; k++) pal_m[k] = '0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk(pix_valid_o == 1'b0, "R1", 32'(pix_valid_o), 0);
    chk(word_ready_o == 1'b1, "R1", 32'(word_ready_o), 1);
    rst_n = 1'b1;
    @(posedge clk); #1;
    send_word(32'h0003_0201, 2'd0, "R1");
    wait_idle();

    // R2 position load, bits above 7:0 ignored
    reg_write(3'd0, 32'h0000_0140);
    reg_write(3'd4, 32'h0011_2233);
    reg_write(3'd4, 32'h0044_5566);
    send_word(32'h4141_4140, 2'd0, "R2");
    wait_idle();

    // R3 wrap from 255 to 0
    reg_write(3'd0, 32'd255);
    reg_write(3'd4, 32'h00A1_B2C3);
    reg_write(3'd4, 32'h00D4_E5F6);
    send_word(32'h00FF_00FF, 2'd0, "R3");
    wait_idle();

    // R9 channel mapping, alpha ignored
    reg_write(3'd0, 32'h10);
    reg_write(3'd4, 32'hAB12_3456);
    reg_write(3'd4, 32'h0012_3456);
    send_word(32'h1110_1110, 2'd0, "R9");
    wait_idle();

    // R4 other offsets: table and position untouched
    reg_write(3'd4, 32'h00CC_DDEE);
    reg_write(3'd2, 32'h0077_7777);
    reg_write(3'd6, 32'h0088_8888);
    reg_write(3'd1, 32'h0000_0033);
    reg_write(3'd4, 32'h0099_AABB);
    send_word(32'h1413_1312, 2'd0, "R4");
    wait_idle();

    // fill whole table from 0
    reg_write(3'd0, 32'h0);
    for (int k = 0; k < 256; k++)
      reg_write(3'd4, {8'(~k), 8'(k*7+1), 8'(k*3), 8'(k ^ 8'h5A)});

    rnd_ready = 1;
    for (int n = 0; n < 40; n++) send_word($urandom(), 2'd0, "R5");
    for (int n = 0; n < 40; n++) send_word($urandom(), 2'd1, "R6");
    send_word(32'hFFFF_8000, 2'd2, "R7");
    send_word(32'h7C1F_03E0, 2'd2, "R7");
    for (int n = 0; n < 30; n++) send_word($urandom(), 2'd2, "R7");
    send_word(32'hFFFF_0000, 2'd3, "R8");
    send_word(32'hF800_07E0, 2'd3, "R8");
    for (int n = 0; n < 30; n++) send_word($urandom(), 2'd3, "R8");
    // mixed formats back to back
    for (int n = 0; n < 40; n++) send_word($urandom(), 2'($urandom_range(0, 3)), "R10");
    wait_idle();

    // R11 format change while a word drains
    rnd_ready = 0;
    pix_ready_i = 1'b0;
    send_word(32'h8765_4321, 2'd1, "R11");
    fmt_i = 2'd3;
    repeat (3) @(posedge clk);
    #1;
    fmt_i = 2'd2;
    rnd_ready = 1;
    wait_idle();

    repeat (4) @(posedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule